// File: doc/BRIEF.md
# Multi-PHY Transmit Address Poller

This block is the cell-layer master of a multi-PHY transmit link. It owns a 5-bit PHY address bus and a single flow-control input that all PHYs share. It walks the address bus over the attached PHYs and records in a per-PHY ready bitmap whether each one can take a whole cell. The status for an address comes back one clock after that address was driven, so each answer is credited to the previous address. When the upstream side asks for a transfer, the poller picks one ready PHY in round-robin order and drives that PHY's address for one selection cycle. It then counts the cell's byte cycles, and polling goes on during the transfer.

The control is a three-state machine. IDLE waits for a request while the poller runs. IDLE goes to SELECT when a request arrives and at least one PHY is marked ready. SELECT lasts exactly one cycle and always goes on to XFER. XFER lasts one cycle per cell byte and returns to IDLE after the last byte.

Top module: `utx_phy_poller`

## Requirements
- R1: After a synchronous active-high reset, `ready_map` is all zeros, `phy_addr` is 31 (the idle address), and `tx_grant`, `cell_busy` and `cell_done` are low. `sel_phy` is 0, and the round-robin pointer points at the last PHY.
- R2: Outside the selection cycle, `phy_addr` moves by one step per cycle. The sequence is 31 for one cycle after reset, then 0, 1, …, NUM_PHY-1, then 31 for one cycle, then back to 0, and so on.
- R3: The value of `phy_clav` sampled in a cycle becomes the ready bit of the PHY address that was driven in the previous cycle. A high value sets the bit and a low value clears it.
- R4: A `phy_clav` sample that follows a cycle carrying the idle address 31, or a selection cycle, changes no ready bit.
- R5: In IDLE, when `tx_req` is high and any ready bit is set, the block grants the first ready PHY found by searching upward (with wrap) from the PHY after the last one granted. After reset, the last one granted counts as NUM_PHY-1.
- R6: The selection cycle follows the granting edge. In it, `tx_grant` is high for exactly one cycle, and `phy_addr` and `sel_phy` both carry the granted PHY. The poll position is held, so the poll sequence resumes where it stopped.
- R7: The granted PHY's ready bit is cleared on the granting edge. This clear wins over a status sample credited to the same PHY on that edge.
- R8: `cell_busy` is high for exactly CELL_BYTES (53) cycles, starting the cycle after the selection cycle. `cell_done` is high only in the last of those cycles. `tx_req` is ignored while in SELECT or XFER, and polling continues throughout.
- R9: `phy_addr` only ever carries a PHY number below NUM_PHY or the idle address 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req | input | 1 | Upstream request to send one cell |
| phy_clav | input | 1 | Shared cell-available response, one cycle after the address |
| phy_addr | output | 5 | PHY address bus (poll or selection) |
| tx_grant | output | 1 | High during the one-cycle selection |
| sel_phy | output | 5 | PHY chosen by the latest grant |
| ready_map | output | NUM_PHY | Per-PHY cell-space bitmap |
| cell_busy | output | 1 | High while the cell's byte cycles run |
| cell_done | output | 1 | High on the last byte cycle |

## Verification
On one edge, the status crediting for the previously polled PHY and the grant clear of the chosen PHY can target the same ready bit. This happens when the granted PHY is the one polled just before the grant. The bench sets up this case by holding `tx_req` high while every PHY reports room, so grants land right after the chosen PHY's poll. A pseudo-random phase then varies requests and room. A behavioural model with clear-wins priority predicts `ready_map` every cycle. Samples that follow the selection cycle are driven high, so any wrongly credited sample shows up as a stray ready bit.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_SELECT, ST_XFER} utx_state_e;
    localparam int          UTX_ADDR_W    = 5;
    localparam logic [4:0]  UTX_IDLE_ADDR = 5'h1F;
endpackage

// File: rtl/utx_poll_seq.sv
module utx_poll_seq
    import utx_pkg::*;
#(
    parameter int NUM_PHY = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_go,
    input  logic [UTX_ADDR_W-1:0] sel_idx,
    output logic [UTX_ADDR_W-1:0] bus_addr,
    output logic [UTX_ADDR_W-1:0] cred_addr,
    output logic                  cred_vld
);
    localparam logic [UTX_ADDR_W-1:0] LAST_A = UTX_ADDR_W'(NUM_PHY - 1);

    logic [UTX_ADDR_W-1:0] pptr_q, pptr_nxt;
    logic                  is_poll_q;

    // poll position after the current one: 0..LAST, idle slot, wrap
    always_comb begin
        if (pptr_q == LAST_A)             pptr_nxt = UTX_IDLE_ADDR;
        else if (pptr_q == UTX_IDLE_ADDR) pptr_nxt = '0;
        else                              pptr_nxt = pptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pptr_q    <= '0;
            bus_addr  <= UTX_IDLE_ADDR;
            is_poll_q <= 1'b0;
            cred_addr <= UTX_IDLE_ADDR;
            cred_vld  <= 1'b0;
        end else begin
            cred_addr <= bus_addr;
            cred_vld  <= is_poll_q;
            if (sel_go) begin
                bus_addr  <= sel_idx;
                is_poll_q <= 1'b0;
            end else begin
                bus_addr  <= pptr_q;
                is_poll_q <= (pptr_q != UTX_IDLE_ADDR);
                pptr_q    <= pptr_nxt;
            end
        end
    end
endmodule

// File: rtl/utx_ready_map.sv
module utx_ready_map
    import utx_pkg::*;
#(
    parameter int NUM_PHY = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cred_vld,
    input  logic [UTX_ADDR_W-1:0] cred_addr,
    input  logic                  clav,
    input  logic                  clr_go,
    input  logic [UTX_ADDR_W-1:0] clr_idx,
    output logic [NUM_PHY-1:0]    map
);
    for (genvar g = 0; g < NUM_PHY; g++) begin : g_bit
        localparam logic [UTX_ADDR_W-1:0] MY_A = UTX_ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst)                                  map[g] <= 1'b0;
            else if (clr_go && clr_idx == MY_A)       map[g] <= 1'b0;
            else if (cred_vld && cred_addr == MY_A)   map[g] <= clav;
        end
    end
endmodule

// File: rtl/utx_rr_pick.sv
module utx_rr_pick
    import utx_pkg::*;
#(
    parameter int NUM_PHY = 4
) (
    input  logic [NUM_PHY-1:0]    map,
    input  logic [UTX_ADDR_W-1:0] last_idx,
    output logic                  found,
    output logic [UTX_ADDR_W-1:0] pick
);
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 1; i <= NUM_PHY; i++) begin
            int idx;
            idx = (int'(last_idx) + i) % NUM_PHY;
            if (!found && map[idx]) begin
                found = 1'b1;
                pick  = UTX_ADDR_W'(idx);
            end
        end
    end
endmodule

// File: rtl/utx_phy_poller.sv
module utx_phy_poller
    import utx_pkg::*;
#(
    parameter int NUM_PHY    = 4,
    parameter int CELL_BYTES = 53
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_req,
    input  logic                  phy_clav,
    output logic [UTX_ADDR_W-1:0] phy_addr,
    output logic                  tx_grant,
    output logic [UTX_ADDR_W-1:0] sel_phy,
    output logic [NUM_PHY-1:0]    ready_map,
    output logic                  cell_busy,
    output logic                  cell_done
);
    localparam int                    CNT_W     = $clog2(CELL_BYTES);
    localparam logic [CNT_W-1:0]      LAST_BYTE = CNT_W'(CELL_BYTES - 1);
    localparam logic [UTX_ADDR_W-1:0] LAST_A    = UTX_ADDR_W'(NUM_PHY - 1);

    utx_state_e            state_q;
    logic [CNT_W-1:0]      byte_q;
    logic [UTX_ADDR_W-1:0] rr_q, sel_q, pick, cred_addr;
    logic                  found, go, cred_vld;

    assign go = (state_q == ST_IDLE) && tx_req && found;

    utx_poll_seq #(.NUM_PHY(NUM_PHY)) u_poll (
        .clk(clk), .rst(rst), .sel_go(go), .sel_idx(pick),
        .bus_addr(phy_addr), .cred_addr(cred_addr), .cred_vld(cred_vld)
    );

    utx_ready_map #(.NUM_PHY(NUM_PHY)) u_map (
        .clk(clk), .rst(rst), .cred_vld(cred_vld), .cred_addr(cred_addr),
        .clav(phy_clav), .clr_go(go), .clr_idx(pick), .map(ready_map)
    );

    utx_rr_pick #(.NUM_PHY(NUM_PHY)) u_pick (
        .map(ready_map), .last_idx(rr_q), .found(found), .pick(pick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            rr_q    <= LAST_A;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    state_q <= ST_SELECT;
                    rr_q    <= pick;
                    sel_q   <= pick;
                end
                ST_SELECT: begin
                    state_q <= ST_XFER;
                    byte_q  <= '0;
                end
                ST_XFER: begin
                    if (byte_q == LAST_BYTE) state_q <= ST_IDLE;
                    else                     byte_q  <= byte_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_grant  = 1'b0;
        cell_busy = 1'b0;
        cell_done = 1'b0;
        sel_phy   = sel_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SELECT: tx_grant = 1'b1;
            ST_XFER: begin
                cell_busy = 1'b1;
                cell_done = (byte_q == LAST_BYTE);
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/utx_phy_poller_chk.sv
module utx_phy_poller_chk
    import utx_pkg::*;
#(
    parameter int NUM_PHY    = 4,
    parameter int CELL_BYTES = 53
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tx_req,
    input logic [UTX_ADDR_W-1:0] phy_addr,
    input logic                  tx_grant,
    input logic [UTX_ADDR_W-1:0] sel_phy,
    input logic [NUM_PHY-1:0]    ready_map,
    input logic                  cell_busy,
    input logic                  cell_done
);
    int run_cnt;
    always_ff @(posedge clk) begin
        if (rst || !cell_busy) run_cnt <= 0;
        else                   run_cnt <= run_cnt + 1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready_map == '0 && phy_addr == UTX_IDLE_ADDR && !cell_busy));

    p_addr_legal_r9: assert property (@(posedge clk) disable iff (rst)
        (int'(phy_addr) < NUM_PHY) || (phy_addr == UTX_IDLE_ADDR));

    p_grant_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_grant) |-> $past(tx_req));

    p_grant_single_r6: assert property (@(posedge clk) disable iff (rst)
        tx_grant |=> !tx_grant);

    p_grant_addr_r6: assert property (@(posedge clk) disable iff (rst)
        tx_grant |-> phy_addr == sel_phy);

    p_grant_clears_r7: assert property (@(posedge clk) disable iff (rst)
        tx_grant |-> !ready_map[sel_phy]);

    p_grant_to_xfer_r8: assert property (@(posedge clk) disable iff (rst)
        tx_grant |=> cell_busy);

    p_done_len_r8: assert property (@(posedge clk) disable iff (rst)
        cell_done |-> (cell_busy && run_cnt == CELL_BYTES - 1));

    p_done_ends_r8: assert property (@(posedge clk) disable iff (rst)
        cell_done |=> !cell_busy);
endmodule

bind utx_phy_poller utx_phy_poller_chk #(.NUM_PHY(NUM_PHY), .CELL_BYTES(CELL_BYTES)) u_chk (
    .clk(clk), .rst(rst), .tx_req(tx_req), .phy_addr(phy_addr), .tx_grant(tx_grant),
    .sel_phy(sel_phy), .ready_map(ready_map), .cell_busy(cell_busy), .cell_done(cell_done)
);

// File: tb/utx_phy_poller_tb.sv
module utx_phy_poller_tb_top;
    localparam int NUM_PHY = 4;
    localparam int CB      = 53;
    localparam int IDLE_A  = 31;

    logic clk = 1'b0;
    logic rst, tx_req, phy_clav;
    logic [4:0] phy_addr, sel_phy;
    logic tx_grant, cell_busy, cell_done;
    logic [NUM_PHY-1:0] ready_map;

    always #4 clk = ~clk;

    utx_phy_poller #(.NUM_PHY(NUM_PHY), .CELL_BYTES(CB)) dut_i (
        .clk(clk), .rst(rst), .tx_req(tx_req), .phy_clav(phy_clav),
        .phy_addr(phy_addr), .tx_grant(tx_grant), .sel_phy(sel_phy),
        .ready_map(ready_map), .cell_busy(cell_busy), .cell_done(cell_done)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    // behavioural reference state
    int m_st, m_cnt, m_addr, m_addr_d, m_pptr, m_rr, m_sel;
    bit m_poll, m_poll_d;
    bit m_rdy[NUM_PHY];
    bit room[NUM_PHY];
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_st = 0; m_cnt = 0; m_addr = IDLE_A; m_addr_d = IDLE_A; m_pptr = 0;
        m_rr = NUM_PHY - 1; m_sel = 0; m_poll = 0; m_poll_d = 0;
        foreach (m_rdy[i]) m_rdy[i] = 0;
    endtask

    function automatic int exp_map();
        int v = 0;
        for (int i = 0; i < NUM_PHY; i++) if (m_rdy[i]) v |= (1 << i);
        return v;
    endfunction

    task automatic compare(input string pfx);
        chk({pfx, "R2/R6 phy_addr"}, int'(phy_addr), m_addr);
        chk({pfx, "R3/R4/R7 ready_map"}, int'(ready_map), exp_map());
        chk({pfx, "R5/R6 tx_grant"}, int'(tx_grant), int'(m_st == 1));
        chk({pfx, "R6 sel_phy"}, int'(sel_phy), m_sel);
        chk({pfx, "R8 cell_busy"}, int'(cell_busy), int'(m_st == 2));
        chk({pfx, "R8 cell_done"}, int'(cell_done), int'(m_st == 2 && m_cnt == CB - 1));
    endtask

    task automatic m_step(input bit req, input bit clav);
        bit go = 0;
        int pick = 0;
        if (m_st == 0 && req) begin
            for (int i = 1; i <= NUM_PHY; i++) begin
                int j = (m_rr + i) % NUM_PHY;
                if (!go && m_rdy[j]) begin go = 1; pick = j; end
            end
        end
        if (m_poll_d) m_rdy[m_addr_d] = clav;
        if (go) m_rdy[pick] = 0;          // clear wins (R7)
        m_addr_d = m_addr;
        m_poll_d = m_poll;
        if (go) begin
            m_addr = pick; m_poll = 0;
        end else begin
            m_addr = m_pptr; m_poll = (m_pptr != IDLE_A);
            if (m_pptr == NUM_PHY - 1) m_pptr = IDLE_A;
            else if (m_pptr == IDLE_A) m_pptr = 0;
            else m_pptr++;
        end
        case (m_st)
            0: if (go) begin m_st = 1; m_rr = pick; m_sel = pick; end
            1: begin m_st = 2; m_cnt = 0; end
            default: if (m_cnt == CB - 1) m_st = 0; else m_cnt++;
        endcase
    endtask

    initial begin
        rst = 1; tx_req = 0; phy_clav = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_reset();
        compare("R1 reset: ");
        for (int k = 0; k < 1500 && !done_flag; k++) begin
            bit req, clav;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (k < 40) begin
                req = 0;
                for (int i = 0; i < NUM_PHY; i++) room[i] = (i % 2 == 0);
            end else if (k < 500) begin
                req = 1;
                for (int i = 0; i < NUM_PHY; i++) room[i] = 1;
            end else if (k < 700) begin
                req = (k % 3 != 0);
                for (int i = 0; i < NUM_PHY; i++) room[i] = (i == 2);
            end else begin
                req = lfsr[0] & lfsr[3];
                for (int i = 0; i < NUM_PHY; i++) room[i] = lfsr[i + 4];
            end
            // response to the address driven last cycle; forced high when it must be ignored (R4)
            clav = (m_poll_d && m_addr_d < NUM_PHY) ? room[m_addr_d] : 1'b1;
            tx_req = req; phy_clav = clav;
            m_step(req, clav);
            @(negedge clk);
            compare("");
        end
        done_flag = 1;
    end

    initial begin : watchdog
        fork
            begin repeat (20000) @(posedge clk); end
            begin wait (done_flag); end
        join_any
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule